// File: doc/BRIEF.md
# Inbound DMA Window Translator

This block sits on the receive side of a PCI host bridge and turns addresses issued by bus-master devices into local memory addresses. Three programmable inbound windows are held in a small 32-bit register file. Each window is based at PCI address zero. Its extent comes from a 64-bit size mask, and a 64-bit local base is added to the incoming address when the window matches.

A lookup is presented as a 64-bit PCI address with a valid strobe. One clock later the block reports a hit or a miss, the index of the winning window and the translated local address. Software programs the windows through single-cycle register writes. A read returns the selected register one cycle after the read strobe. Every register write takes effect for the next lookup cycle, so there is no separate commit step.

Top module: `dma_inwin_xlate`

## Requirements
- R1: After reset every window's size mask is 0xFFFF_FFFF_0000_0000 (size-low reads 0, size-high reads 0xFFFF_FFFF), every local base is zero, the status register reads zero, and every lookup misses.
- R2: A window takes part in lookups only while bit 0 of its size mask is 1; with that bit 0 an address inside its range misses.
- R3: The window size is the two's complement of the 64-bit mask with bits 2:0 forced to zero. An address hits when it is below that size. A mask that is zero above bit 2 covers the whole 64-bit space.
- R4: On a hit the local address is the window's local base plus the PCI address, modulo 2^64.
- R5: When several enabled windows cover an address, the one with the lowest index (0, then 1, then 2) is reported.
- R6: When no enabled window covers the address, the miss flag is raised and the window index and local address are reported as zero.
- R7: Register offsets are fixed. Window 0 uses 0x98 (size low), 0x9C (base low), 0xA0 (base high) and 0xF8 (size high). Window 2 uses 0xB0, 0xB4, 0xB8 and 0xFC in the same roles. A write replaces only the addressed 32-bit half, and a read returns all 32 written bits, including mask bits 2:1.
- R8: Window 1 has one 32-bit size register at 0xA4 (the low mask half), with its base at 0xA8 (low) and 0xAC (high). The upper half of its mask is fixed at all ones, so its size never exceeds 2^32.
- R9: Offset 0xE0 is a 32-bit status register that reads back what was last written to it.
- R10: A write to any other offset changes no state, and a read of any other offset returns zero. reg_rdata is zero in any cycle that follows a cycle without a read.
- R11: A lookup result appears in the cycle after lk_valid. A read result appears in the cycle after reg_rd. A lookup presented in the same cycle as a register write uses the configuration from before the write; the next lookup uses the new one.
- R12: rsp_valid is high exactly in the cycle after lk_valid was high. During that cycle exactly one of rsp_hit and rsp_miss is high, and neither is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one cycle after reg_rd |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 2*DATA_W | PCI address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An enabled window covers the address |
| rsp_miss | output | 1 | No enabled window covers the address |
| rsp_win | output | 2 | Index of the winning window |
| rsp_laddr | output | 2*DATA_W | Translated local address |

## Verification
A register write and a lookup can fall in the same clock cycle, and the lookup must then see the configuration from before the write. The bench provokes this by driving the write that enables window 0 together with a lookup that window 1 also covers. It expects window 1 for that lookup and window 0 for the lookup that follows. The same question is asked of the half-register writes: after the upper base half of a live window changes, the next lookup must show the new upper half together with the old lower half.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int NWIN   = 3;
  localparam int IW     = 2;
  localparam int OFF_W  = 8;

  // register offsets, one byte each, indexed by window
  localparam logic [NWIN-1:0][OFF_W-1:0] OFF_SLO = {8'hB0, 8'hA4, 8'h98};
  localparam logic [NWIN-1:0][OFF_W-1:0] OFF_BLO = {8'hB4, 8'hA8, 8'h9C};
  localparam logic [NWIN-1:0][OFF_W-1:0] OFF_BHI = {8'hB8, 8'hAC, 8'hA0};
  localparam logic [NWIN-1:0][OFF_W-1:0] OFF_SHI = {8'hFC, 8'h00, 8'hF8};
  localparam logic [NWIN-1:0]            HAS_SHI = 3'b101;
  localparam logic [OFF_W-1:0]           OFF_STAT = 8'hE0;
endpackage

// File: rtl/dmaw_regfile.sv
module dmaw_regfile
  import dmaw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW    = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [OFF_W-1:0]           addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [NWIN-1:0][AW-1:0]    mask_o,
  output logic [NWIN-1:0][AW-1:0]    base_o
);
  logic [NWIN-1:0][DATA_W-1:0] msk_lo, msk_hi, bas_lo, bas_hi;
  logic [DATA_W-1:0]           stat_q;
  logic [DATA_W-1:0]           rd_mux;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        msk_lo[w] <= '0;
        bas_lo[w] <= '0;
        bas_hi[w] <= '0;
      end else if (wr_en) begin
        if (addr == OFF_SLO[w]) msk_lo[w] <= wdata;
        if (addr == OFF_BLO[w]) bas_lo[w] <= wdata;
        if (addr == OFF_BHI[w]) bas_hi[w] <= wdata;
      end
    end

    if (HAS_SHI[w]) begin : g_shi
      always_ff @(posedge clk) begin
        if (rst)                               msk_hi[w] <= '1;
        else if (wr_en && addr == OFF_SHI[w])  msk_hi[w] <= wdata;
      end
    end else begin : g_fixed
      assign msk_hi[w] = '1;
    end

    assign mask_o[w] = {msk_hi[w], msk_lo[w]};
    assign base_o[w] = {bas_hi[w], bas_lo[w]};
  end

  always_ff @(posedge clk) begin
    if (rst)                          stat_q <= '0;
    else if (wr_en && addr == OFF_STAT) stat_q <= wdata;
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (addr == OFF_SLO[w]) rd_mux = msk_lo[w];
      if (addr == OFF_BLO[w]) rd_mux = bas_lo[w];
      if (addr == OFF_BHI[w]) rd_mux = bas_hi[w];
      if (HAS_SHI[w] && addr == OFF_SHI[w]) rd_mux = msk_hi[w];
    end
    if (addr == OFF_STAT) rd_mux = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst)  rdata <= '0;
    else      rdata <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/dmaw_match.sv
module dmaw_match #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] mask,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] laddr
);
  localparam logic [AW-1:0] LOW_RSV = AW'(7);

  logic [AW-1:0] eff;
  logic [AW-1:0] size;

  always_comb begin
    eff   = mask & ~LOW_RSV;
    size  = ~eff + AW'(1);
    hit   = mask[0] && ((eff == '0) || (addr < size));
    laddr = base + addr;
  end
endmodule

// File: rtl/dmaw_pick.sv
module dmaw_pick #(
  parameter int NW = 3,
  parameter int IW = 2,
  parameter int AW = 64
) (
  input  logic [NW-1:0]         hits,
  input  logic [NW-1:0][AW-1:0] laddrs,
  output logic                  any,
  output logic [IW-1:0]         idx,
  output logic [AW-1:0]         laddr
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    laddr = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (hits[w]) begin
        any   = 1'b1;
        idx   = IW'(w);
        laddr = laddrs[w];
      end
    end
  end
endmodule

// File: rtl/dma_inwin_xlate.sv
module dma_inwin_xlate
  import dmaw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              lk_valid,
  input  logic [AW-1:0]     lk_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IW-1:0]     rsp_win,
  output logic [AW-1:0]     rsp_laddr
);
  logic [NWIN-1:0][AW-1:0] masks, bases, laddrs;
  logic [NWIN-1:0]         hits;
  logic                    any_hit;
  logic [IW-1:0]           sel_idx;
  logic [AW-1:0]           sel_laddr;

  dmaw_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .mask_o(masks), .base_o(bases)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    dmaw_match #(.AW(AW)) u_match (
      .mask(masks[w]), .base(bases[w]), .addr(lk_addr),
      .hit(hits[w]), .laddr(laddrs[w])
    );
  end

  dmaw_pick #(.NW(NWIN), .IW(IW), .AW(AW)) u_pick (
    .hits(hits), .laddrs(laddrs),
    .any(any_hit), .idx(sel_idx), .laddr(sel_laddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_laddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & any_hit;
      rsp_miss  <= lk_valid & ~any_hit;
      rsp_win   <= (lk_valid & any_hit) ? sel_idx : '0;
      rsp_laddr <= (lk_valid & any_hit) ? sel_laddr : '0;
    end
  end
endmodule

// File: rtl/dmaw_xlate_chk.sv
module dmaw_xlate_chk
  import dmaw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AW    = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic [OFF_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              lk_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [IW-1:0]     rsp_win,
  input logic [AW-1:0]     rsp_laddr
);
  logic mapped;
  always_comb begin
    case (reg_addr)
      8'h98, 8'h9C, 8'hA0, 8'hF8, 8'hA4, 8'hA8, 8'hAC,
      8'hB0, 8'hB4, 8'hB8, 8'hFC, 8'hE0: mapped = 1'b1;
      default:                           mapped = 1'b0;
    endcase
  end

  p_result_follows_r11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

  p_hit_xor_miss_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));

  p_miss_zeroed_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_win == '0 && rsp_laddr == '0));

  p_win_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_win < IW'(NWIN)));

  p_rd_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));

  p_rd_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !mapped) |=> (reg_rdata == '0));
endmodule

bind dma_inwin_xlate dmaw_xlate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
  .rsp_laddr(rsp_laddr)
);

// File: tb/dma_inwin_xlate_bench.sv
module dma_inwin_xlate_bench;
  localparam int DW = 32;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_miss;
  logic [1:0]    rsp_win;
  logic [AW-1:0] rsp_laddr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_inwin_xlate #(.DATA_W(DW)) u_dma_inwin_xlate (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
    .rsp_laddr(rsp_laddr)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, {96'b0, reg_rdata}, {96'b0, exp});
  endtask

  task automatic look(input logic [AW-1:0] a, input bit hit, input logic [1:0] win,
                      input logic [AW-1:0] la, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_laddr},
               {1'b1, hit, ~hit, win, la});
  endtask

  task automatic t_reset;
    rd(8'h98, 32'h0, "R1 w0 size low");
    rd(8'hF8, 32'hFFFF_FFFF, "R1 w0 size high");
    rd(8'h9C, 32'h0, "R1 w0 base low");
    rd(8'hA0, 32'h0, "R1 w0 base high");
    rd(8'hA4, 32'h0, "R1 w1 size");
    rd(8'hB0, 32'h0, "R1 w2 size low");
    rd(8'hFC, 32'hFFFF_FFFF, "R1 w2 size high");
    rd(8'hE0, 32'h0, "R1 status");
    look(64'h0, 1'b0, 2'd0, 64'h0, "R1 R6 miss after reset");
  endtask

  task automatic t_enable;
    wr(8'h9C, 32'h4000_0000);
    wr(8'hA0, 32'h1);
    wr(8'h98, 32'hFFFF_F000);
    look(64'h10, 1'b0, 2'd0, 64'h0, "R2 disabled window misses");
    wr(8'h98, 32'hFFFF_F001);
    look(64'h10, 1'b1, 2'd0, 64'h1_4000_0010, "R2 R4 enabled hit");
  endtask

  task automatic t_size;
    look(64'hFFF, 1'b1, 2'd0, 64'h1_4000_0FFF, "R3 last in range");
    look(64'h1000, 1'b0, 2'd0, 64'h0, "R3 first past range");
    wr(8'h98, 32'hFFFF_F007);
    rd(8'h98, 32'hFFFF_F007, "R7 low bits read back");
    look(64'h1000, 1'b0, 2'd0, 64'h0, "R3 reserved bits ignored");
    look(64'hFFF, 1'b1, 2'd0, 64'h1_4000_0FFF, "R3 reserved bits ignored hit");
  endtask

  task automatic t_half;
    wr(8'hA0, 32'h2);
    rd(8'h9C, 32'h4000_0000, "R7 low half kept");
    rd(8'hA0, 32'h2, "R7 high half replaced");
    look(64'h10, 1'b1, 2'd0, 64'h2_4000_0010, "R7 new base in use");
  endtask

  task automatic t_win1;
    wr(8'hA8, 32'h8000_0000);
    wr(8'hAC, 32'h0);
    wr(8'hA4, 32'h0000_0001);
    rd(8'hA4, 32'h1, "R8 w1 size readback");
    look(64'hFFFF_FFFF, 1'b1, 2'd1, 64'h1_7FFF_FFFF, "R8 w1 top of 4G");
    look(64'h1_0000_0000, 1'b0, 2'd0, 64'h0, "R8 w1 capped at 4G");
  endtask

  task automatic t_prio;
    look(64'h20, 1'b1, 2'd0, 64'h2_4000_0020, "R5 lowest index wins");
    wr(8'h98, 32'hFFFF_F006);
    look(64'h20, 1'b1, 2'd1, 64'h8000_0020, "R5 next window after disable");
  endtask

  task automatic t_full;
    wr(8'hB4, 32'h0000_0010);
    wr(8'hB8, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h0);
    wr(8'hB0, 32'h0000_0001);
    look(64'h2_0000_0000, 1'b1, 2'd2, 64'h1_0000_0010, "R3 R4 full space and wrap");
    look(64'h20, 1'b1, 2'd1, 64'h8000_0020, "R5 w1 beats w2");
  endtask

  task automatic t_status;
    wr(8'hE0, 32'hA5A5_5A5A);
    rd(8'hE0, 32'hA5A5_5A5A, "R9 status readback");
  endtask

  task automatic t_unmapped;
    wr(8'hC0, 32'hFFFF_FFFF);
    wr(8'h94, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h0, "R10 unmapped read zero");
    rd(8'h94, 32'h0, "R10 unmapped read zero 2");
    rd(8'hE0, 32'hA5A5_5A5A, "R10 status untouched");
    rd(8'hA4, 32'h1, "R10 w1 untouched");
    look(64'h20, 1'b1, 2'd1, 64'h8000_0020, "R10 lookup unchanged");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h98; reg_wdata = 32'hFFFF_F001;
    lk_valid = 1'b1; lk_addr = 64'h20;
    @(negedge clk);
    reg_wr = 1'b0; lk_valid = 1'b0;
    check("R11 same-cycle lookup uses old config",
          {rsp_valid, rsp_hit, rsp_win, rsp_laddr}, {1'b1, 1'b1, 2'd1, 64'h8000_0020});
    @(negedge clk);
    check("R12 no result without lookup", {rsp_valid, rsp_hit, rsp_miss}, 3'b000);
    look(64'h20, 1'b1, 2'd0, 64'h2_4000_0020, "R11 next lookup uses new config");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 idle after reset", {rsp_valid, rsp_hit, rsp_miss, reg_rdata}, 35'h0);
    t_reset();
    t_enable();
    t_size();
    t_half();
    t_win1();
    t_prio();
    t_full();
    t_status();
    t_unmapped();
    t_same_cycle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule